// File: doc/BRIEF.md
# Sleep Wakeup Alarm Timer

This block keeps the board's sleep alarm. A host loads a wake time and an offset, a byte at a time, through a small register port. A real-time-clock seconds count comes in on an input, and the block compares it with the stored wake time. Instead of writing an absolute wake time, the host can ask the block to set the wake time to the current clock value plus the offset.

Sleep is requested only while the host has set both the enable bit and the arm bit. While the board sleeps, the block raises a one-cycle wake pulse when the clock reaches the wake time, or when a button press arrives and button wake is not masked. The reason for the last wake is held on a cause output. The arm bit drops when the board wakes.

Top module: `slp_wake_timer`

## Requirements
- R1: The wake time is a 32-bit value held in byte registers at addresses 1 to 4, with the least significant byte at address 1. Each byte reads back at its own address.
- R2: The offset is a 32-bit value held in byte registers at addresses 5 to 8, with the least significant byte at address 5. Each byte reads back at its own address.
- R3: Control register 0 holds four bits: bit 0 is enable, bit 1 is arm, bit 2 masks button wake, and bit 3 is latch. Writing bit 3 as 1 makes it read 1 for exactly one cycle. On the next clock edge the wake time becomes the clock value plus the offset, modulo 2^32, and bit 3 then reads 0.
- R4: `sleep_req` is high only while bit 0 and bit 1 are both set. With either bit clear, a reached wake time or a button press gives no wake pulse.
- R5: While asleep with bit 2 clear, a high `button_press` at a clock edge produces a wake pulse with cause 1. With bit 2 set, the button has no effect.
- R6: While asleep, if the clock value is at or past the wake time at a clock edge, `wake_pulse` is high for the following cycle and the arm bit clears, so `sleep_req` falls.
- R7: "At or past" means the difference (clock value minus wake time), taken as a signed 32-bit number, is not negative. A wake time that has wrapped past zero is therefore still reached correctly.
- R8: `wake_cause` holds 6 after a timer wake and 1 after a button wake. When both happen in the same cycle, the cause is 6 and only one pulse is given.
- R9: After reset, every register reads 0, `sleep_req` and `wake_pulse` are 0, and `wake_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address, used for both write and read |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| rtc_sec | input | 32 | Free-running seconds count from the real-time clock |
| button_press | input | 1 | Button pressed this cycle |
| sleep_req | output | 1 | Sleep requested (enable and arm both set) |
| wake_pulse | output | 1 | One-cycle wake event |
| wake_cause | output | 4 | Cause of the last wake (6 timer, 1 button) |

## Verification
The timer match and a button press can both be true at the same clock edge. The bench provokes this by holding the button high while it sweeps the clock value from just below the wake time to just past it, with button wake both masked and unmasked. In each case there must be exactly one pulse, the cause must be 6 whenever the time was reached, and the arm bit must have cleared. A latch request can also coincide with a live compare. The bench checks that the compare in that cycle uses the old wake time and that the new sum is visible one cycle later.

// File: rtl/swt_pkg.sv
package swt_pkg;
  localparam int unsigned CAUSE_W     = 4;
  localparam logic [3:0]  CAUSE_NONE  = 4'd0;
  localparam logic [3:0]  CAUSE_BTN   = 4'd1;
  localparam logic [3:0]  CAUSE_TIMER = 4'd6;

  // control register layout
  localparam int unsigned CTRL_ADDR   = 0;
  localparam int unsigned WAKE_BASE   = 1;
  localparam int unsigned BIT_EN      = 0;
  localparam int unsigned BIT_ARM     = 1;
  localparam int unsigned BIT_NOBTN   = 2;
  localparam int unsigned BIT_LATCH   = 3;
endpackage

// File: rtl/swt_regfile.sv
module swt_regfile
  import swt_pkg::*;
#(
  parameter int unsigned RTC_W  = 32,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [RTC_W-1:0]  rtc,
  input  logic              clr_arm,
  output logic [RTC_W-1:0]  wake_time,
  output logic [RTC_W-1:0]  offset_val,
  output logic              en,
  output logic              arm,
  output logic              no_btn,
  output logic              latch_pend,
  output logic              ctrl_wr
);
  localparam int unsigned NBYTES    = RTC_W / DATA_W;
  localparam int unsigned OFFS_BASE = WAKE_BASE + NBYTES;

  // wrapping sum used by the latch request
  function automatic logic [RTC_W-1:0] wrap_add(input logic [RTC_W-1:0] a,
                                                input logic [RTC_W-1:0] b);
    return a + b;
  endfunction

  logic [RTC_W-1:0] wake_q, offs_q;
  logic             en_q, arm_q, nobtn_q, latch_q;

  assign ctrl_wr = wr_en && (addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_q  <= '0;
      offs_q  <= '0;
      en_q    <= 1'b0;
      arm_q   <= 1'b0;
      nobtn_q <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      for (int i = 0; i < NBYTES; i++) begin
        if (wr_en && addr == ADDR_W'(WAKE_BASE + i)) wake_q[i*DATA_W +: DATA_W] <= wdata;
        if (wr_en && addr == ADDR_W'(OFFS_BASE + i)) offs_q[i*DATA_W +: DATA_W] <= wdata;
      end
      if (latch_q) wake_q <= wrap_add(rtc, offs_q);
      if (ctrl_wr) begin
        en_q    <= wdata[BIT_EN];
        arm_q   <= wdata[BIT_ARM];
        nobtn_q <= wdata[BIT_NOBTN];
        latch_q <= wdata[BIT_LATCH];
      end else begin
        latch_q <= 1'b0;
        if (clr_arm) arm_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      rdata[BIT_EN]    = en_q;
      rdata[BIT_ARM]   = arm_q;
      rdata[BIT_NOBTN] = nobtn_q;
      rdata[BIT_LATCH] = latch_q;
    end
    for (int i = 0; i < NBYTES; i++) begin
      if (addr == ADDR_W'(WAKE_BASE + i)) rdata = wake_q[i*DATA_W +: DATA_W];
      if (addr == ADDR_W'(OFFS_BASE + i)) rdata = offs_q[i*DATA_W +: DATA_W];
    end
  end

  assign wake_time  = wake_q;
  assign offset_val = offs_q;
  assign en         = en_q;
  assign arm        = arm_q;
  assign no_btn     = nobtn_q;
  assign latch_pend = latch_q;
endmodule

// File: rtl/swt_wake_ctl.sv
module swt_wake_ctl
  import swt_pkg::*;
#(
  parameter int unsigned RTC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               asleep,
  input  logic               no_btn,
  input  logic               button,
  input  logic [RTC_W-1:0]   rtc,
  input  logic [RTC_W-1:0]   wake_time,
  output logic               timer_hit,
  output logic               button_hit,
  output logic               fire,
  output logic               wake_pulse,
  output logic [CAUSE_W-1:0] wake_cause
);
  // reached when the signed distance from target to now is not negative
  function automatic logic time_reached(input logic [RTC_W-1:0] now,
                                        input logic [RTC_W-1:0] target);
    logic [RTC_W-1:0] diff;
    diff = now - target;
    return ~diff[RTC_W-1];
  endfunction

  assign timer_hit  = asleep && time_reached(rtc, wake_time);
  assign button_hit = asleep && button && !no_btn;
  assign fire       = timer_hit || button_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_pulse <= 1'b0;
      wake_cause <= CAUSE_NONE;
    end else begin
      wake_pulse <= fire;
      if (timer_hit)       wake_cause <= CAUSE_TIMER;
      else if (button_hit) wake_cause <= CAUSE_BTN;
    end
  end
endmodule

// File: rtl/slp_wake_timer.sv
module slp_wake_timer
  import swt_pkg::*;
#(
  parameter int unsigned RTC_W  = 32,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [RTC_W-1:0]  rtc_sec,
  input  logic              button_press,
  output logic              sleep_req,
  output logic              wake_pulse,
  output logic [3:0]        wake_cause
);
  logic [RTC_W-1:0] wake_time, offset_val;
  logic en, arm, no_btn, latch_pend, ctrl_wr;
  logic timer_hit, button_hit, fire, asleep;

  assign asleep    = en && arm;
  assign sleep_req = asleep;

  swt_regfile #(.RTC_W(RTC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .rtc(rtc_sec), .clr_arm(fire), .wake_time(wake_time),
    .offset_val(offset_val), .en(en), .arm(arm), .no_btn(no_btn),
    .latch_pend(latch_pend), .ctrl_wr(ctrl_wr)
  );

  swt_wake_ctl #(.RTC_W(RTC_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .asleep(asleep), .no_btn(no_btn),
    .button(button_press), .rtc(rtc_sec), .wake_time(wake_time),
    .timer_hit(timer_hit), .button_hit(button_hit), .fire(fire),
    .wake_pulse(wake_pulse), .wake_cause(wake_cause)
  );
endmodule

// File: rtl/swt_checker.sv
module swt_checker #(
  parameter int unsigned RTC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_req,
  input logic             wake_pulse,
  input logic [3:0]       wake_cause,
  input logic             latch_pend,
  input logic             ctrl_wr,
  input logic             timer_hit,
  input logic             button_hit,
  input logic [RTC_W-1:0] wake_time,
  input logic [RTC_W-1:0] offset_val,
  input logic [RTC_W-1:0] rtc_sec
);
  assert_latch_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pend |=> wake_time == $past(rtc_sec + offset_val));

  assert_latch_self_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pend && !ctrl_wr |=> !latch_pend);

  assert_no_wake_awake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_req |=> !wake_pulse);

  assert_button_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    button_hit && !timer_hit |=> wake_pulse && wake_cause == 4'd1);

  assert_arm_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> !sleep_req || $past(ctrl_wr));

  assert_timer_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timer_hit |=> wake_pulse && wake_cause == 4'd6);
endmodule

bind slp_wake_timer swt_checker #(.RTC_W(RTC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_pulse(wake_pulse),
  .wake_cause(wake_cause), .latch_pend(latch_pend), .ctrl_wr(ctrl_wr),
  .timer_hit(timer_hit), .button_hit(button_hit), .wake_time(wake_time),
  .offset_val(offset_val), .rtc_sec(rtc_sec)
);

// File: tb/tb_slp_wake_timer.sv
`timescale 1ns/1ps
module tb_slp_wake_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [31:0] rtc_sec = '0;
  logic        button_press = 1'b0;
  logic        sleep_req, wake_pulse;
  logic [3:0]  wake_cause;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  slp_wake_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rtc_sec(rtc_sec),
    .button_press(button_press), .sleep_req(sleep_req),
    .wake_pulse(wake_pulse), .wake_cause(wake_cause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic write_word(input logic [3:0] base, input logic [31:0] v);
    for (int i = 0; i < 4; i++) write_reg(base + 4'(i), v[i*8 +: 8]);
  endtask

  task automatic read_word(input logic [3:0] base, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      read_reg(base + 4'(i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  // one sleep/wake trial: clock is at wake time + d, button level b, mask m
  task automatic trial(input logic [31:0] w, input int d, input bit b, input bit m);
    bit exp_fire, tmr;
    logic [31:0] rb;
    write_word(4'd1, w);
    read_word(4'd1, rb);
    check("R1 wake readback", rb, w);
    rtc_sec = w + 32'(d);
    button_press = b;
    write_reg(4'd0, {5'b0, m, 2'b11});
    check("R4 sleep_req armed", 32'(sleep_req), 32'd1);
    tmr = (d >= 0);
    exp_fire = tmr || (b && !m);
    @(negedge clk);
    check(tmr ? "R6 R7 timer pulse" : "R5 button pulse", 32'(wake_pulse), 32'(exp_fire));
    if (exp_fire) begin
      check("R8 cause", 32'(wake_cause), tmr ? 32'd6 : 32'd1);
      check("R6 arm cleared", 32'(sleep_req), 32'd0);
    end
    button_press = 1'b0;
    write_reg(4'd0, 8'h00);
    check("R6 single pulse", 32'(wake_pulse), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    logic [7:0]  c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 sleep_req", 32'(sleep_req), 32'd0);
    check("R9 wake_pulse", 32'(wake_pulse), 32'd0);
    check("R9 cause", 32'(wake_cause), 32'd0);
    for (int a = 0; a < 9; a++) begin
      read_reg(4'(a), c);
      check("R9 register zero", 32'(c), 32'd0);
    end

    // R2 offset bytes, least significant at address 5
    write_word(4'd5, 32'hA1B2C3D4);
    read_reg(4'd5, c); check("R2 offset low byte", 32'(c), 32'hD4);
    read_reg(4'd8, c); check("R2 offset high byte", 32'(c), 32'hA1);

    // R4 only one control bit set: no sleep, no wake
    write_word(4'd1, 32'd10);
    rtc_sec = 32'd50;
    button_press = 1'b1;
    write_reg(4'd0, 8'h01);
    check("R4 enable only", 32'(sleep_req), 32'd0);
    @(negedge clk);
    check("R4 enable only no pulse", 32'(wake_pulse), 32'd0);
    write_reg(4'd0, 8'h02);
    check("R4 arm only", 32'(sleep_req), 32'd0);
    @(negedge clk);
    check("R4 arm only no pulse", 32'(wake_pulse), 32'd0);
    button_press = 1'b0;
    write_reg(4'd0, 8'h00);

    // sweep around two wake times, one of them straddling the wrap
    for (int k = 0; k < 2; k++)
      for (int d = -3; d <= 3; d++)
        for (int bm = 0; bm < 4; bm++)
          trial(k == 0 ? 32'h1000_0000 : 32'hFFFF_FFFE, d, bm[0], bm[1]);

    // R3 latch: rtc + offset wraps
    rtc_sec = 32'hFFFF_FFF0;
    write_word(4'd5, 32'h0000_0020);
    write_reg(4'd0, 8'h08);
    read_reg(4'd0, c);
    check("R3 latch bit pending", 32'(c[3]), 32'd1);
    @(negedge clk);
    read_reg(4'd0, c);
    check("R3 latch bit cleared", 32'(c[3]), 32'd0);
    read_word(4'd1, v);
    check("R3 R7 wrapped sum", v, 32'hFFFF_FFF0 + 32'h20);

    // R7 wrapped target not yet reached from just below zero
    write_reg(4'd0, 8'h07);
    @(negedge clk);
    check("R7 before wrap no pulse", 32'(wake_pulse), 32'd0);
    rtc_sec = 32'h0000_0010;
    @(negedge clk);
    check("R7 wrapped target reached", 32'(wake_pulse), 32'd1);
    check("R8 timer cause", 32'(wake_cause), 32'd6);
    write_reg(4'd0, 8'h00);

    // latch and live compare in the same cycle: old target used
    write_word(4'd1, 32'd100);
    write_word(4'd5, 32'd1000);
    rtc_sec = 32'd100;
    write_reg(4'd0, 8'h0F);
    @(negedge clk);
    check("R3 compare uses old target", 32'(wake_pulse), 32'd1);
    read_word(4'd1, v);
    check("R3 latch sum visible", v, 32'd1100);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule